// File: doc/BRIEF.md
# Frame-Synchronised Serial Output Port

This block is the device side of a serial output link in which the host supplies the frame timing. The host drives a free-running bit clock and a frame marker. The block runs on the converter's master clock. It counts master-clock cycles between successive frame markers and decides whether the frame is 256 or 512 cycles long. It reports an unsupported spacing with a flag that stays set until reset.

At the start of each frame the block loads the current 24-bit result. It sends the result most significant bit first, one bit per falling bit-clock edge. Serial data arriving on the chain input is shifted in behind the word, so the output can be wired into the next device's chain input to form a daisy chain.

The bit clock and frame marker are oversampled by the master clock. The bit clock is at least four master cycles long in every supported mode, so a plain registered edge detector is enough to follow it.

Top module: `fsync_tx_port`

## Requirements
- R1: While reset is asserted, `dout`, `locked`, `len_long` and `frame_err` are all 0.
- R2: A frame rising edge is detected when `fsync`, registered on `clk`, reads 1 after having read 0 one sample earlier. The measured length is the number of `clk` cycles between two consecutive detected edges. The first edge after reset yields no measurement.
- R3: A measurement is valid when it equals 256, or when it equals 512 with `hs_mode` at 0. Every valid measurement sets `len_long` to 1 for 512 and to 0 for 256.
- R4: `locked` becomes 1 only at a detected edge whose valid measurement equals the previous measurement, and that previous measurement must also have been valid. Any other measurement clears `locked`.
- R5: An invalid measurement sets `frame_err`, and it stays 1 until reset.
- R6: After an invalid measurement, `dout` is held at 0 until the next valid measurement.
- R7: At a detected frame edge the block loads `data_word`. From the next cycle `dout` shows bit 23.
- R8: At each falling edge of the registered `sclk`, `dout` moves to the next lower bit of the word. `dout` changes at no other time, except when a frame edge is detected.
- R9: The `din` value sampled with each falling `sclk` edge is appended behind the word. After the 24 word bits, `dout` therefore carries the chain input bits in the order they arrived.
- R10: When a frame edge and an `sclk` falling edge are detected in the same cycle, the load wins and bit 23 is shown.
- R11: With `hs_mode` at 1, a 512-cycle frame is treated as invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hs_mode | input | 1 | High-speed mode: only 256-cycle frames are accepted |
| sclk | input | 1 | Free-running bit clock from the host |
| fsync | input | 1 | Frame marker from the host; its rising edge starts a frame |
| din | input | 1 | Chain input from the upstream device |
| data_word | input | 24 | Result word loaded at each frame start |
| dout | output | 1 | Serial output, most significant bit first |
| locked | output | 1 | Two consecutive matching valid frame lengths have been seen |
| len_long | output | 1 | Last valid frame length was 512 |
| frame_err | output | 1 | Sticky flag for an unsupported frame length |

## Verification
The assertions check on every cycle that the error flag never clears, and that the lock and length flags move only at a detected frame edge. They also check that the output never changes without a frame or bit-clock event, that the output is low in the cycle the error flag rises, and that a high-speed lock never reports the long frame. The bench scenarios are needed for the rest. Only they can show that the word leaves in the right bit order, that the chain bits follow it in arrival order, and that the lock needs exactly two matching frames. They also show recovery after a bad frame, and the load winning over a shift when both fall on the same cycle. These are compared against a queue-based reference model on every clock.

// File: rtl/fsync_tx_port.sv
module fsync_tx_port #(
  parameter int WORD_W    = 24,
  parameter int SHORT_LEN = 256,
  parameter int LONG_LEN  = 512,
  localparam int CNT_W    = $clog2(LONG_LEN) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hs_mode,
  input  logic              sclk,
  input  logic              fsync,
  input  logic              din,
  input  logic [WORD_W-1:0] data_word,
  output logic              dout,
  output logic              locked,
  output logic              len_long,
  output logic              frame_err
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic sc1, sc2, fs1, fs2, din1;
  logic [CNT_W-1:0] cnt, cand;
  logic cand_ok, seen, blank;
  logic [WORD_W-1:0] shreg;

  wire fs_rise = fs1 & ~fs2;
  wire sc_fall = sc2 & ~sc1;
  wire is_short = (cnt == CNT_W'(SHORT_LEN));
  wire is_long  = (cnt == CNT_W'(LONG_LEN));
  wire meas_ok  = is_short | (is_long & ~hs_mode);

  assign dout = shreg[WORD_W-1] & ~blank;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {sc1, sc2, fs1, fs2, din1} <= '0;
    end else begin
      sc1  <= sclk;
      sc2  <= sc1;
      fs1  <= fsync;
      fs2  <= fs1;
      din1 <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      cand      <= '0;
      cand_ok   <= 1'b0;
      seen      <= 1'b0;
      blank     <= 1'b0;
      locked    <= 1'b0;
      len_long  <= 1'b0;
      frame_err <= 1'b0;
    end else if (fs_rise) begin
      cnt  <= CNT_W'(1);
      seen <= 1'b1;
      if (seen) begin
        cand    <= cnt;
        cand_ok <= meas_ok;
        locked  <= meas_ok & cand_ok & (cand == cnt);
        blank   <= ~meas_ok;
        if (meas_ok) len_long  <= is_long;
        else         frame_err <= 1'b1;
      end
    end else if (cnt != CNT_MAX) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       shreg <= '0;
    else if (fs_rise) shreg <= data_word;
    else if (sc_fall) shreg <= {shreg[WORD_W-2:0], din1};
  end

endmodule

// File: rtl/fsync_tx_port_chk.sv
module fsync_tx_port_chk (
  input logic clk,
  input logic rst_n,
  input logic hs_mode,
  input logic dout,
  input logic locked,
  input logic len_long,
  input logic frame_err,
  input logic fs_rise,
  input logic sc_fall
);

  a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> frame_err);

  a_r4_lock_at_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !fs_rise |=> $stable(locked));

  a_r3_len_at_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !fs_rise |=> $stable(len_long));

  a_r8_dout_on_event: assert property (@(posedge clk) disable iff (!rst_n)
    (!fs_rise && !sc_fall) |=> $stable(dout));

  a_r6_quiet_on_error: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_err) |-> !dout);

  a_r11_hs_short_only: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_rise && hs_mode) |=> (!locked || !len_long));

endmodule

bind fsync_tx_port fsync_tx_port_chk chk_i (
  .clk(clk), .rst_n(rst_n), .hs_mode(hs_mode), .dout(dout),
  .locked(locked), .len_long(len_long), .frame_err(frame_err),
  .fs_rise(fs_rise), .sc_fall(sc_fall)
);

// File: tb/fsync_tx_port_tb_top.sv
module fsync_tx_port_tb_top;
  logic clk = 1'b0;
  logic rst_n, hs_mode, sclk, fsync, din;
  logic [23:0] data_word;
  logic dout, locked, len_long, frame_err;

  int checks = 0, fails = 0, cycles = 0, gcnt = 0, coincide = 0;
  bit started = 0;

  always #5 clk = ~clk;

  fsync_tx_port dut_i (
    .clk(clk), .rst_n(rst_n), .hs_mode(hs_mode), .sclk(sclk), .fsync(fsync),
    .din(din), .data_word(data_word), .dout(dout), .locked(locked),
    .len_long(len_long), .frame_err(frame_err)
  );

  // reference model state
  logic p1_sc, p2_sc, p1_fs, p2_fs, p1_din;
  int   m_cnt, m_cand;
  bit   m_cand_ok, m_seen, m_blank, m_lock, m_long, m_err;
  logic m_q[$];

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b time=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      {p1_sc, p2_sc, p1_fs, p2_fs, p1_din} = '0;
      m_cnt = 0; m_cand = 0; m_cand_ok = 0; m_seen = 0; m_blank = 0;
      m_lock = 0; m_long = 0; m_err = 0;
      m_q.delete();
      for (int i = 0; i < 24; i++) m_q.push_back(1'b0);
    end else begin
      bit rise, fall, ok;
      rise = p1_fs && !p2_fs;
      fall = p2_sc && !p1_sc;
      if (rise) begin
        if (m_seen) begin
          ok = (m_cnt == 256) || (m_cnt == 512 && !hs_mode);
          m_lock = ok && m_cand_ok && (m_cand == m_cnt);
          m_cand = m_cnt; m_cand_ok = ok;
          m_blank = !ok;
          if (ok) m_long = (m_cnt == 512); else m_err = 1;
        end
        m_seen = 1; m_cnt = 1;
        if (fall) coincide++;
        m_q.delete();
        for (int i = 23; i >= 0; i--) m_q.push_back(data_word[i]);
      end else begin
        if (m_cnt < 1023) m_cnt++;
        if (fall) begin
          void'(m_q.pop_front());
          m_q.push_back(p1_din);
        end
      end
      p2_sc = p1_sc; p1_sc = sclk;
      p2_fs = p1_fs; p1_fs = fsync;
      p1_din = din;
    end
  end

  always @(negedge clk) begin
    if (rst_n && started) begin
      chk("R6 R7 R8 R9 R10 dout", dout, m_blank ? 1'b0 : m_q[0]);
      chk("R4 locked", locked, m_lock);
      chk("R3 len_long", len_long, m_long);
      chk("R5 frame_err", frame_err, m_err);
    end
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic frame(int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      fsync = (i < 8);
      sclk  = 1'((gcnt >> 1) & 1);
      din   = 1'($urandom);
      if (i == 0) data_word = 24'($urandom);
      gcnt++;
    end
  endtask

  initial begin
    rst_n = 0; hs_mode = 0; sclk = 0; fsync = 0; din = 0; data_word = '0;
    repeat (4) @(negedge clk);
    chk("R1 dout", dout, 1'b0);
    chk("R1 locked", locked, 1'b0);
    chk("R1 len_long", len_long, 1'b0);
    chk("R1 frame_err", frame_err, 1'b0);
    rst_n = 1; started = 1;

    repeat (4) frame(256);
    chk("R4 lock short", locked, 1'b1);
    chk("R3 short length", len_long, 1'b0);
    chk("R2 no error", frame_err, 1'b0);

    repeat (3) frame(512);
    chk("R4 lock long", locked, 1'b1);
    chk("R3 long length", len_long, 1'b1);

    hs_mode = 1;
    repeat (2) frame(512);
    chk("R11 long rejected", frame_err, 1'b1);
    chk("R11 no lock", locked, 1'b0);
    chk("R6 output quiet", dout, 1'b0);

    repeat (3) frame(256);
    chk("R5 sticky", frame_err, 1'b1);
    chk("R4 relock hs", locked, 1'b1);

    hs_mode = 0;
    frame(302);
    repeat (4) frame(256);
    chk("R4 relock after bad", locked, 1'b1);
    chk("R5 still set", frame_err, 1'b1);
    checks++;
    if (coincide == 0) begin
      fails++;
      $display("FAIL R10 coincidences actual=%0d expected>0", coincide);
    end

    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule